// File: doc/BRIEF.md
# Bitmask Set/Clear/Invert/Extract Unit

A 64-bit shift-and-mask datapath. From a 6-bit length field it builds a contiguous run of ones that starts at bit 0 and is one bit longer than the field value. The run is then used in one of two ways. For set, clear and invert, the run is moved up by a shift amount and merged into a source word. For the extract operations, the run masks a field taken from the source. That field is either shifted right logically or taken from a bit-reversed copy of the source.

The shift amount is the low six bits of a shift word. The reversed extract has a flag that reports that the shift operand selector was zero. When the flag is set, the unit ignores the shift word and reverses the entire source, subject only to the mask. A single mask generator serves all five operations. The result is captured in one output register, so it appears one clock after the operands are presented.

Top module: `bmask_unit`

## Requirements
- R1: The shift amount is bits [5:0] of `shamt_word_i`. Bits [63:6] have no effect on the result.
- R2: The mask has ones in bits 0..`len_i` and zeros above. A length of 63 gives all ones. A length of 0 gives only bit 0.
- R3: Operation code 0 (set) returns `src | (mask << shamt)`. With a zero source and a zero shift, the result is the bare mask.
- R4: Operation code 1 (clear) returns `src & ~(mask << shamt)`.
- R5: Operation code 2 (invert) returns `src ^ (mask << shamt)`.
- R6: Operation code 3 (extract) returns `mask & (src >> shamt)`. The shift is logical, so vacated high bits are zero and nothing wraps around.
- R7: Operation code 4 (reversed extract) with `shsel_zero_i` low returns `mask & (rev(src) >> (63 - shamt))`. Here rev(src) bit j equals src bit 63-j.
- R8: Operation code 4 with `shsel_zero_i` high ignores `shamt_word_i` and returns `mask & rev(src)`.
- R9: Mask bits that `mask << shamt` pushes past bit 63 are discarded and do not wrap to the low end.
- R10: Operation codes 5, 6 and 7 return the source unchanged.
- R11: The result is registered. Operands presented before a rising edge are reflected on `result_o` after that edge. An active-low reset clears `result_o` to zero.
- R12: `shsel_zero_i` has no effect on operation codes 0 to 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_i | input | 64 | Source word |
| shamt_word_i | input | 64 | Shift word; only the low six bits are used |
| len_i | input | 6 | Mask length field (run length is value + 1) |
| shsel_zero_i | input | 1 | Shift operand selector was zero (used by reversed extract only) |
| op_i | input | 3 | Operation select: 0 set, 1 clear, 2 invert, 3 extract, 4 reversed extract |
| result_o | output | 64 | Registered result |

## Verification
Every clock, the assertions check the relations between source and result that do not depend on the shift: set never drops a source bit, clear never raises one, and invert flips no more than len+1 bits. They also check that an extract holds no more than len+1 ones, that unused codes pass the source through, and that the selector-zero reverse matches a bit-reversed source. The exact placement of the run cannot be shown by these properties and is left to the bench sweep. That sweep covers every shift amount against a spread of lengths, the drop of bits past the top, the 63-minus-shift mapping of the reversed extract, and the insensitivity to upper shift-word bits.

// File: rtl/bmask_pkg.sv
package bmask_pkg;
    localparam int XLEN = 64;
    localparam int SH_W = $clog2(XLEN);

    typedef enum logic [2:0] {
        BM_SET    = 3'd0,
        BM_CLR    = 3'd1,
        BM_INV    = 3'd2,
        BM_EXT    = 3'd3,
        BM_REVEXT = 3'd4
    } bm_op_e;
endpackage

// File: rtl/bmask_run_gen.sv
// Builds ones in bits 0..len; a length of XLEN-1 fills the word.
module bmask_run_gen #(
    parameter int WIDTH = 64,
    localparam int LW   = $clog2(WIDTH)
) (
    input  logic [LW-1:0]    len_i,
    output logic [WIDTH-1:0] run_o
);
    for (genvar g = 0; g < WIDTH; g++) begin : g_bit
        assign run_o[g] = (LW'(g) <= len_i);
    end
endmodule

// File: rtl/bmask_bit_rev.sv
module bmask_bit_rev #(
    parameter int WIDTH = 64
) (
    input  logic [WIDTH-1:0] in_i,
    output logic [WIDTH-1:0] out_o
);
    for (genvar g = 0; g < WIDTH; g++) begin : g_swap
        assign out_o[g] = in_i[WIDTH-1-g];
    end
endmodule

// File: rtl/bmask_core.sv
module bmask_core
    import bmask_pkg::*;
#(
    parameter int WIDTH = XLEN,
    localparam int LW   = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] src_i,
    input  logic [WIDTH-1:0] shamt_word_i,
    input  logic [LW-1:0]    len_i,
    input  logic             shsel_zero_i,
    input  logic [2:0]       op_i,
    output logic [WIDTH-1:0] res_o
);
    localparam logic [LW-1:0] TOP = LW'(WIDTH - 1);

    logic [LW-1:0]    sh;
    logic [LW-1:0]    rev_sh;
    logic [WIDTH-1:0] run;
    logic [WIDTH-1:0] placed;
    logic [WIDTH-1:0] src_rev;
    logic [WIDTH-1:0] ext_fwd;
    logic [WIDTH-1:0] ext_rev;

    assign sh = LW'(shamt_word_i % WIDTH);

    bmask_run_gen #(.WIDTH(WIDTH)) u_run (
        .len_i (len_i),
        .run_o (run)
    );

    bmask_bit_rev #(.WIDTH(WIDTH)) u_rev (
        .in_i  (src_i),
        .out_o (src_rev)
    );

    // Left shift drops bits that leave the top of the word.
    assign placed  = run << sh;
    assign ext_fwd = run & (src_i >> sh);
    // Selector-zero forces shift TOP, so the complementary shift is zero.
    assign rev_sh  = shsel_zero_i ? '0 : (TOP - sh);
    assign ext_rev = run & (src_rev >> rev_sh);

    always_comb begin
        unique case (op_i)
            BM_SET:    res_o = src_i | placed;
            BM_CLR:    res_o = src_i & ~placed;
            BM_INV:    res_o = src_i ^ placed;
            BM_EXT:    res_o = ext_fwd;
            BM_REVEXT: res_o = ext_rev;
            default:   res_o = src_i;
        endcase
    end
endmodule

// File: rtl/bmask_unit.sv
module bmask_unit
    import bmask_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [XLEN-1:0] src_i,
    input  logic [XLEN-1:0] shamt_word_i,
    input  logic [SH_W-1:0] len_i,
    input  logic            shsel_zero_i,
    input  logic [2:0]      op_i,
    output logic [XLEN-1:0] result_o
);
    logic [XLEN-1:0] res_d;

    bmask_core #(.WIDTH(XLEN)) u_core (
        .src_i        (src_i),
        .shamt_word_i (shamt_word_i),
        .len_i        (len_i),
        .shsel_zero_i (shsel_zero_i),
        .op_i         (op_i),
        .res_o        (res_d)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) result_o <= '0;
        else        result_o <= res_d;
    end

    // Set keeps every source bit.
    assert_set_keeps_src_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == BM_SET) |=> ((result_o & $past(src_i)) == $past(src_i)));

    // Clear never raises a bit.
    assert_clr_subset_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == BM_CLR) |=> ((result_o & ~$past(src_i)) == '0));

    // Invert flips at most len+1 bits.
    assert_inv_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == BM_INV) |=> ($countones(result_o ^ $past(src_i)) <= int'($past(len_i)) + 1));

    // Extract yields at most len+1 ones.
    assert_ext_width_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == BM_EXT) |=> ($countones(result_o) <= int'($past(len_i)) + 1));

    // Selector-zero reverse with full mask equals the bit-reversed source.
    assert_rev_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == BM_REVEXT && shsel_zero_i && len_i == SH_W'(XLEN - 1))
        |=> (result_o == {<<{$past(src_i)}}));

    // Unused codes pass the source.
    assert_passthru_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i > 3'd4) |=> (result_o == $past(src_i)));
endmodule

// File: tb/test_bmask_unit.sv
module test_bmask_unit;
    localparam int CLK_PERIOD = 10;
    localparam int W = 64;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [W-1:0]  src_i = '0;
    logic [W-1:0]  shamt_word_i = '0;
    logic [5:0]    len_i = '0;
    logic          shsel_zero_i = 1'b0;
    logic [2:0]    op_i = '0;
    logic [W-1:0]  result_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bmask_unit i_bmask_unit (
        .clk          (clk),
        .rst_n        (rst_n),
        .src_i        (src_i),
        .shamt_word_i (shamt_word_i),
        .len_i        (len_i),
        .shsel_zero_i (shsel_zero_i),
        .op_i         (op_i),
        .result_o     (result_o)
    );

    function automatic logic [W-1:0] model(logic [W-1:0] s, logic [W-1:0] sw,
                                           int len, bit z, int op);
        logic [W-1:0] r;
        logic [W-1:0] pm;
        int sh;
        int rs;
        sh = int'(sw[5:0]);
        rs = z ? 0 : 63 - sh;
        pm = '0;
        for (int i = 0; i < W; i++)
            if (i >= sh && (i - sh) <= len) pm[i] = 1'b1;
        r = '0;
        case (op)
            0: r = s | pm;
            1: r = s & ~pm;
            2: r = s ^ pm;
            3: for (int i = 0; i < W; i++)
                   if (i <= len && i + sh < W) r[i] = s[i + sh];
            4: for (int i = 0; i < W; i++)
                   if (i <= len && i + rs < W) r[i] = s[63 - (i + rs)];
            default: r = s;
        endcase
        return r;
    endfunction

    task automatic check(string tag, logic [W-1:0] exp);
        checks++;
        if (result_o !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, result_o, exp);
        end
    endtask

    task automatic apply(string tag, logic [W-1:0] s, logic [W-1:0] sw,
                         int len, bit z, int op);
        @(negedge clk);
        src_i = s; shamt_word_i = sw; len_i = 6'(len);
        shsel_zero_i = z; op_i = 3'(op);
        @(negedge clk);
        check(tag, model(s, sw, len, z, op));
    endtask

    function automatic string pick_tag(int op, bit z, int sh, int len);
        if (op >= 5) return "R10";
        if (op == 4) return z ? "R8" : "R7";
        if (z) return "R12";
        if (op == 3) return "R6";
        if (sh + len > 63) return "R9";
        if (op == 0) return "R3";
        if (op == 1) return "R4";
        return "R5";
    endfunction

    initial begin
        logic [W-1:0] lfsr;
        int lens[8];
        lens = '{0, 1, 3, 7, 20, 31, 62, 63};
        lfsr = 64'hC0FF_EE12_3456_789B;
        #(CLK_PERIOD * 2);
        @(negedge clk);
        check("R11", '0);
        rst_n = 1'b1;

        apply("R2", '0, '0, 63, 0, 0);
        apply("R2", '0, '0, 0, 0, 0);
        apply("R3", '0, '0, 4, 0, 0);
        apply("R9", '0, 64'd60, 7, 0, 0);
        apply("R1", 64'h0123_4567_89AB_CDEF, 64'hFFFF_FFFF_FFFF_FFC3, 9, 0, 3);
        apply("R1", 64'h0123_4567_89AB_CDEF, 64'h8000_0000_0000_0005, 12, 0, 0);
        apply("R8", 64'h8000_0000_0000_0001, 64'd17, 63, 1, 4);
        apply("R7", 64'h8000_0000_0000_0000, 64'd63, 63, 0, 4);

        for (int op = 0; op < 8; op++)
            for (int li = 0; li < 8; li++)
                for (int sh = 0; sh < 64; sh++)
                    for (int z = 0; z < 2; z++) begin
                        logic [W-1:0] sw;
                        lfsr = {lfsr[62:0], lfsr[63] ^ lfsr[62] ^ lfsr[60] ^ lfsr[59]};
                        sw = {lfsr[63:6], 6'(sh)};
                        apply(pick_tag(op, z[0], sh, lens[li]), lfsr, sw,
                              lens[li], z[0], op);
                    end

        // R11: reset clears a nonzero result
        apply("R11", '1, '0, 0, 0, 7);
        #1 rst_n = 1'b0;
        #1 check("R11", '0);
        done = 1;
    end

    initial begin
        #(CLK_PERIOD * 60000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got hung expected completion");
        end
        done = 1;
    end

    initial begin
        wait (done);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule